// File: doc/BRIEF.md
# Serial Character Transmitter with Line Routing

This block turns 8-bit characters into asynchronous serial frames and drives them onto a transmit pin. A character is written into a one-entry holding stage. From there it moves into a shift stage, which sends a low start bit, the eight data bits least significant first, an optional parity bit and a high stop bit. Every bit lasts sixteen pulses of an oversample tick that arrives from outside the block. The transmitter reports two flags. The ready flag means the holding stage can take a character. The empty flag means nothing is held and nothing is being shifted.

A two-bit routing mode decides what drives the transmit pin and what feeds the local receiver. The choices are straight-through, echo of the incoming line, an internal loop of the transmitter into the receiver, and a pass-through of the incoming line back out. Single-cycle strobes enable, disable and reset the transmitter. Separate strobes enable, disable and reset the receiver input. The receiver itself, the divisor that produces the tick, and the bus registers belong to other blocks.

Top module: `uart_tx_chan`

## Requirements
- R1: Out of reset the transmit pin is high, both flags are low, the transmitter is disabled and the receiver input is held high.
- R2: A transmit enable strobe raises the ready flag and, with nothing pending, the empty flag. A transmit disable strobe lowers both flags. When both strobes arrive in the same cycle, disable wins.
- R3: A write is accepted only while the ready flag is high, and ready falls in the cycle after an accepted write. A write while ready is low (holding stage full, or transmitter disabled) is dropped and never appears on the line.
- R4: A frame is a 0 start bit, 8 data bits least significant first, an optional parity bit and a 1 stop bit. Each bit lasts 16 oversample ticks. A held character starts its start bit on the clock edge after it is written, if the shift stage is idle.
- R5: The parity-mode encoding is: 0 even (data plus parity has an even count of ones), 1 odd, 2 parity bit forced to 0, 3 parity bit forced to 1. Codes 4 to 7 send no parity bit, which gives a 10-bit frame.
- R6: The empty flag is low from an accepted write until the clock edge that takes the 16th tick of the final stop bit, and high from that edge on.
- R7: A character written during a frame is sent right after that frame, and characters leave in the order they were written.
- R8: A transmitter reset strobe aborts the frame in progress and discards the held character. The transmit pin is high from the next edge, and the flags read as idle.
- R9: Routing code 0: the transmitter drives the transmit pin, and the receive pin feeds the receiver.
- R10: Routing code 1: the receive pin drives the transmit pin and still feeds the receiver. The transmitter output is not seen.
- R11: Routing code 2: the transmitter output feeds the receiver, and the transmit pin is held high.
- R12: Routing code 3: the receive pin drives the transmit pin, and the receiver input is held high.
- R13: The receiver input follows the routing only after a receive enable strobe. A receive disable or receive reset strobe forces it high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample tick, 16 per bit |
| tx_wr | input | 1 | Write strobe for a character |
| tx_data | input | 8 | Character to send |
| tx_en | input | 1 | Transmitter enable strobe |
| tx_dis | input | 1 | Transmitter disable strobe |
| tx_rst | input | 1 | Transmitter reset strobe |
| rx_en | input | 1 | Receiver input enable strobe |
| rx_dis | input | 1 | Receiver input disable strobe |
| rx_rst | input | 1 | Receiver reset strobe |
| par_mode | input | 3 | Parity selection |
| chan_mode | input | 2 | Line routing selection |
| rxd_pin | input | 1 | Receive pin |
| txd_pin | output | 1 | Transmit pin |
| rx_line | output | 1 | Serial input to the local receiver |
| tx_ready | output | 1 | Holding stage can take a character |
| tx_empty | output | 1 | Holding and shift stages both idle |

## Verification
The flags react one edge after a strobe or an accepted write. A frame starts one edge after the write, and the routing outputs follow their inputs with no delay. The bench therefore drives on falling edges and reads the flags and routed pins at the next falling edge. The monitor decodes frames by counting the ticks it sees at each rising edge. It reads each bit at tick 8 of that bit, so the sample never falls on a bit boundary. It checks that the empty flag is still low halfway through the stop bit and is high right after the edge that takes the final tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    ROUTE_NORMAL = 2'd0,
    ROUTE_ECHO   = 2'd1,
    ROUTE_LOCAL  = 2'd2,
    ROUTE_REMOTE = 2'd3
  } route_e;

  typedef enum logic [2:0] {
    PAR_EVEN  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_SPACE = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_NONE  = 3'd4
  } par_e;

  // codes at or above the "none" code send no parity bit
  function automatic logic par_present(input logic [2:0] mode);
    return mode < PAR_NONE;
  endfunction

endpackage

// File: rtl/uart_tx_enables.sv
module uart_tx_enables (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_dis,
  input  logic rx_en,
  input  logic rx_dis,
  input  logic rx_rst,
  output logic tx_on,
  output logic rx_on
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on <= 1'b0;
      rx_on <= 1'b0;
    end else begin
      if (tx_dis)      tx_on <= 1'b0;
      else if (tx_en)  tx_on <= 1'b1;
      if (rx_dis || rx_rst) rx_on <= 1'b0;
      else if (rx_en)       rx_on <= 1'b1;
    end
  end

  // R2
  tx_dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dis |=> !tx_on);

  // R13
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dis || rx_rst) |=> !rx_on);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              tx_on,
  input  logic              tx_rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [2:0]        par_mode,
  output logic              tx_line,
  output logic              tx_ready,
  output logic              tx_empty
);

  localparam int FW = DATA_W + 3;
  localparam int CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam int BW = $clog2(FW + 1);
  localparam logic [CW-1:0] TICK_LAST = CW'(OS_RATE - 1);

  function automatic logic par_value(input logic [DATA_W-1:0] d, input logic [2:0] m);
    case (par_e'(m))
      PAR_EVEN:  return ^d;
      PAR_ODD:   return ~^d;
      PAR_SPACE: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic [FW-1:0] build_frame(input logic [DATA_W-1:0] d, input logic [2:0] m);
    if (par_present(m)) return {1'b1, par_value(d, m), d, 1'b0};
    return {2'b11, d, 1'b0};
  endfunction

  function automatic logic [BW-1:0] frame_len(input logic [2:0] m);
    return par_present(m) ? BW'(FW) : BW'(FW - 1);
  endfunction

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [FW-1:0]     shreg;
  logic              busy;
  logic [CW-1:0]     tick_cnt;
  logic [BW-1:0]     bits_left;

  // named internal events
  logic wr_accept, load_now, bit_done, frame_done;
  assign wr_accept  = tx_wr && tx_ready;
  assign load_now   = tx_on && hold_full && !busy;
  assign bit_done   = busy && os_tick && (tick_cnt == TICK_LAST);
  assign frame_done = bit_done && (bits_left == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      shreg     <= '1;
      busy      <= 1'b0;
      tick_cnt  <= '0;
      bits_left <= '0;
    end else if (tx_rst) begin
      hold_full <= 1'b0;
      shreg     <= '1;
      busy      <= 1'b0;
      tick_cnt  <= '0;
      bits_left <= '0;
    end else begin
      if (wr_accept) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if (load_now) begin
        shreg     <= build_frame(hold_q, par_mode);
        bits_left <= frame_len(par_mode);
        tick_cnt  <= '0;
        busy      <= 1'b1;
        hold_full <= 1'b0;
      end else if (busy && os_tick) begin
        if (bit_done) begin
          tick_cnt  <= '0;
          shreg     <= {1'b1, shreg[FW-1:1]};
          bits_left <= bits_left - BW'(1);
          if (frame_done) busy <= 1'b0;
        end else begin
          tick_cnt <= tick_cnt + CW'(1);
        end
      end
    end
  end

  assign tx_line  = shreg[0];
  assign tx_ready = tx_on && !hold_full;
  assign tx_empty = tx_on && !hold_full && !busy;

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (tx_line && !busy));

  // R3
  wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !tx_rst) |=> !tx_ready);

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !tx_rst) |=> !tx_line);

  // R6
  empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_line);

  // R4
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left != '0));

endmodule

// File: rtl/uart_chan_route.sv
module uart_chan_route
  import uart_tx_pkg::*;
(
  input  logic [1:0] chan_mode,
  input  logic       tx_line,
  input  logic       rxd_pin,
  input  logic       rx_on,
  output logic       txd_pin,
  output logic       rx_line
);

  logic rx_src;

  always_comb begin
    case (route_e'(chan_mode))
      ROUTE_ECHO:   begin txd_pin = rxd_pin; rx_src = rxd_pin; end
      ROUTE_LOCAL:  begin txd_pin = 1'b1;    rx_src = tx_line; end
      ROUTE_REMOTE: begin txd_pin = rxd_pin; rx_src = 1'b1;    end
      default:      begin txd_pin = tx_line; rx_src = rxd_pin; end
    endcase
    rx_line = rx_on ? rx_src : 1'b1;
  end

endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_en,
  input  logic              tx_dis,
  input  logic              tx_rst,
  input  logic              rx_en,
  input  logic              rx_dis,
  input  logic              rx_rst,
  input  logic [2:0]        par_mode,
  input  logic [1:0]        chan_mode,
  input  logic              rxd_pin,
  output logic              txd_pin,
  output logic              rx_line,
  output logic              tx_ready,
  output logic              tx_empty
);

  logic tx_on, rx_on, tx_line;

  uart_tx_enables u_en (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_dis(tx_dis),
    .rx_en(rx_en), .rx_dis(rx_dis), .rx_rst(rx_rst),
    .tx_on(tx_on), .rx_on(rx_on)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_sh (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .tx_on(tx_on), .tx_rst(tx_rst), .tx_wr(tx_wr), .tx_data(tx_data),
    .par_mode(par_mode), .tx_line(tx_line),
    .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  uart_chan_route u_rt (
    .chan_mode(chan_mode), .tx_line(tx_line), .rxd_pin(rxd_pin),
    .rx_on(rx_on), .txd_pin(txd_pin), .rx_line(rx_line)
  );

  // R11
  local_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == ROUTE_LOCAL) |-> txd_pin);

  // R12
  remote_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == ROUTE_REMOTE) |-> (txd_pin == rxd_pin && rx_line));

  // R10
  echo_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == ROUTE_ECHO) |-> (txd_pin == rxd_pin));

  // R13
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |-> rx_line);

endmodule

// File: tb/sim_uart_tx_chan.sv
module sim_uart_tx_chan;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_en = 0, tx_dis = 0, tx_rst = 0, rx_en = 0, rx_dis = 0, rx_rst = 0;
  logic [2:0] par_mode = 3'd0;
  logic [1:0] chan_mode = 2'd0;
  logic rxd_pin = 1'b1;
  logic txd_pin, rx_line, tx_ready, tx_empty;

  always #10 clk = ~clk;

  uart_tx_chan u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_en(tx_en), .tx_dis(tx_dis), .tx_rst(tx_rst),
    .rx_en(rx_en), .rx_dis(rx_dis), .rx_rst(rx_rst),
    .par_mode(par_mode), .chan_mode(chan_mode), .rxd_pin(rxd_pin),
    .txd_pin(txd_pin), .rx_line(rx_line), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick every third cycle, driven on the falling edge
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt++;
      os_tick = (tcnt % 3 == 0);
    end
  end

  // scoreboard queues
  logic [11:0] exp_bits[$];
  int          exp_len[$];
  string       exp_tag[$];
  bit mon_on = 1, mon_sel = 0, mon_active = 0;

  function automatic void push_frame(input logic [7:0] d, input logic [2:0] m, input string tag);
    logic [11:0] b;
    int ones = 0;
    logic p;
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      b[i+1] = d[i];
      if (d[i]) ones++;
    end
    case (m)
      3'd0: p = (ones % 2 == 1);
      3'd1: p = (ones % 2 == 0);
      3'd2: p = 1'b0;
      default: p = 1'b1;
    endcase
    if (m < 3'd4) begin
      b[9] = p; b[10] = 1'b1;
      exp_len.push_back(11);
    end else begin
      b[9] = 1'b1;
      exp_len.push_back(10);
    end
    exp_bits.push_back(b);
    exp_tag.push_back(tag);
  endfunction

  // monitor: decodes frames by counting ticks
  initial begin
    int cnt = 0, len = 11;
    logic [11:0] got = '1;
    bit bogus = 0;
    logic t, line;
    forever begin
      @(posedge clk);
      t = os_tick;
      #1;
      line = mon_sel ? rx_line : txd_pin;
      if (!mon_on) begin
        mon_active = 0;
      end else if (!mon_active) begin
        if (rst_n && line == 1'b0) begin
          mon_active = 1; cnt = 0; got = '1;
          if (exp_bits.size() == 0) begin
            check(0, "R3 unexpected frame on line", 1, 0);
            bogus = 1; len = 11;
          end else begin
            bogus = 0; len = exp_len[0];
          end
        end
      end else if (t) begin
        cnt++;
        if (cnt % 16 == 8) got[cnt/16] = line;
        if (cnt == 16*len - 8 && !mon_sel)
          check(tx_empty == 1'b0, "R6 empty low during stop bit", tx_empty, 0);
        if (cnt == 16*len) begin
          mon_active = 0;
          if (!bogus) begin
            logic [11:0] e;
            string tg;
            bit ok = 1;
            e = exp_bits.pop_front();
            void'(exp_len.pop_front());
            tg = exp_tag.pop_front();
            for (int i = 0; i < len; i++) if (got[i] !== e[i]) ok = 0;
            check(ok, tg, got, e);
            if (exp_bits.size() == 0 && !mon_sel)
              check(tx_empty == 1'b1, "R6 empty after last stop tick", tx_empty, 1);
          end
        end
      end
    end
  end

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input bit push, input string tag);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    if (push) push_frame(d, par_mode, tag);
    @(negedge clk);
    tx_wr = 1'b0;
    check(tx_ready == 1'b0, "R3 ready low after accepted write", tx_ready, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_bits.size() != 0 || mon_active || !tx_empty) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(txd_pin == 1'b1, "R1 pin high in reset", txd_pin, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd_pin == 1'b1 && rx_line == 1'b1, "R1 lines idle after reset", {txd_pin, rx_line}, 3);
    check(tx_ready == 0 && tx_empty == 0, "R1 flags low after reset", {tx_ready, tx_empty}, 0);

    strobe(tx_en);
    check(tx_ready == 1 && tx_empty == 1, "R2 enable raises flags", {tx_ready, tx_empty}, 3);
    strobe(rx_en);

    // R4 R5 frames in each parity mode
    par_mode = 3'd0;
    send_char(8'hA5, 1, "R4 even frame A5");
    wait_idle();
    send_char(8'h01, 1, "R5 even frame 01");
    wait_idle();
    par_mode = 3'd1;
    send_char(8'h37, 1, "R5 odd frame 37");
    wait_idle();
    par_mode = 3'd2;
    send_char(8'hFF, 1, "R5 space frame FF");
    wait_idle();
    par_mode = 3'd3;
    send_char(8'h00, 1, "R5 mark frame 00");
    wait_idle();
    par_mode = 3'd4;
    send_char(8'h5A, 1, "R5 no-parity frame 5A");
    wait_idle();
    par_mode = 3'd6;
    send_char(8'hC3, 1, "R5 code 6 no-parity frame C3");
    wait_idle();

    // R7 back-to-back, plus a write dropped while full (R3)
    par_mode = 3'd0;
    send_char(8'h11, 1, "R7 first of burst");
    send_char(8'h22, 1, "R7 second of burst");
    check(tx_ready == 1'b0, "R3 holding full", tx_ready, 0);
    tx_data = 8'hEE; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    send_char(8'h33, 1, "R7 third of burst");
    wait_idle();

    // R3 write while disabled is dropped
    strobe(tx_dis);
    check(tx_ready == 0 && tx_empty == 0, "R2 disable lowers flags", {tx_ready, tx_empty}, 0);
    tx_data = 8'h77; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    strobe(tx_en);
    check(tx_empty == 1'b1 && tx_ready == 1'b1, "R3 disabled write not held", {tx_ready, tx_empty}, 3);
    begin
      bit stay = 1;
      repeat (200) begin @(negedge clk); if (!txd_pin) stay = 0; end
      check(stay, "R3 line idle after dropped write", stay, 1);
    end

    // R2 both strobes together
    @(negedge clk); tx_en = 1; tx_dis = 1;
    @(negedge clk); tx_en = 0; tx_dis = 0;
    check(tx_ready == 1'b0, "R2 disable wins", tx_ready, 0);
    strobe(tx_en);

    // R8 abort
    mon_on = 0;
    send_char(8'h0F, 0, "R8");
    repeat (40) @(negedge clk);
    send_char(8'hF0, 0, "R8");
    strobe(tx_rst);
    check(txd_pin == 1'b1 && tx_ready && tx_empty, "R8 abort to idle", {txd_pin, tx_ready, tx_empty}, 7);
    begin
      bit stay = 1;
      repeat (700) begin @(negedge clk); if (!txd_pin) stay = 0; end
      check(stay, "R8 held character discarded", stay, 1);
    end
    mon_on = 1;

    // R11 local loopback
    chan_mode = 2'd2; mon_sel = 1; rxd_pin = 1'b0;
    @(negedge clk);
    check(txd_pin == 1'b1, "R11 pin held high", txd_pin, 1);
    send_char(8'h3C, 1, "R11 looped frame 3C");
    wait_idle();
    check(txd_pin == 1'b1, "R11 pin high after frame", txd_pin, 1);
    mon_sel = 0; rxd_pin = 1'b1;

    // R10 echo
    mon_on = 0;
    chan_mode = 2'd1; rxd_pin = 1'b0;
    @(negedge clk);
    check(txd_pin == 0 && rx_line == 0, "R10 echo low", {txd_pin, rx_line}, 0);
    rxd_pin = 1'b1;
    send_char(8'h00, 0, "R10");
    begin
      bit stay = 1;
      repeat (300) begin @(negedge clk); if (!txd_pin) stay = 0; end
      check(stay, "R10 transmitter hidden", stay, 1);
    end
    while (!tx_empty) @(negedge clk);

    // R12 remote
    chan_mode = 2'd3; rxd_pin = 1'b0;
    @(negedge clk);
    check(txd_pin == 0 && rx_line == 1, "R12 remote routing", {txd_pin, rx_line}, 1);

    // R9 normal
    chan_mode = 2'd0;
    @(negedge clk);
    check(txd_pin == 1 && rx_line == 0, "R9 normal routing", {txd_pin, rx_line}, 2);

    // R13 receiver gating
    strobe(rx_dis);
    check(rx_line == 1'b1, "R13 disable forces high", rx_line, 1);
    strobe(rx_en);
    check(rx_line == 1'b0, "R13 enable follows pin", rx_line, 0);
    strobe(rx_rst);
    check(rx_line == 1'b1, "R13 reset forces high", rx_line, 1);
    rxd_pin = 1'b1;
    mon_on = 1;

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule